// File: doc/BRIEF.md
# Background debug command sequencer

This block runs on the host side of a single-wire debug link. It issues one debug command at a time to a target over an open-drain line that idles high. A command starts with an 8-bit opcode. Depending on its class, the opcode is followed by a 16-bit address, by 16 bits of outgoing data, or by 16 bits of data coming back from the target. The sequencer inserts a fixed wait, counted in clock cycles, at the point where the class requires the target to finish its work: before the read data, after the write data, or after a command that resumes the target.

The user starts a command with a one-cycle `start_i` strobe. On that strobe the block captures the class, opcode, address, write data and acknowledge-mode enable. It raises `busy_o` while the command runs and pulses `done_o` once at the end. With acknowledge mode on, each fixed wait is replaced by waiting for the target to pull the line low. A timeout bounds that wait and sets an error flag if the pulse never arrives.

The bit serializer and deserializer, the line synchronizer and the delay counters are all inside the block. Every bit is framed by a falling edge that the host drives. The length of the low pulse encodes a transmitted bit. A received bit is read from the line at a fixed point after the host's falling edge.

Top module: `bgnd_cmd_seq`

## Requirements
- R1: Transmitted bits go out most significant bit first. A 1 is a low pulse of `LOW1_CYC` cycles, a 0 is a low pulse of `LOW0_CYC` cycles, and the line is released (high) at all other times. The line is never driven while the block is idle, and no low pulse lasts longer than `LOW0_CYC` cycles.
- R2: Each bit occupies exactly `BIT_CYC` cycles, and the bits of consecutive serial phases follow one another with no gap.
- R3: Class 0 (hardware read) sends the opcode, then the 16-bit address, waits `DLY_HW` cycles, then receives 16 bits. `done_o` rises 40·`BIT_CYC`+`DLY_HW` cycles after the start edge, and `rdata_o` then holds the received word.
- R4: Class 1 (hardware write) sends the opcode, the address and the 16-bit write data, then waits `DLY_HW` cycles. `done_o` rises 40·`BIT_CYC`+`DLY_HW` cycles after the start edge.
- R5: Class 2 (firmware read) sends the opcode, waits `DLY_FW_RD` cycles, then receives 16 bits. `done_o` rises 24·`BIT_CYC`+`DLY_FW_RD` cycles after the start edge.
- R6: Class 3 (firmware write) sends the opcode and the 16-bit write data, then waits `DLY_FW_WR` cycles. `done_o` rises 24·`BIT_CYC`+`DLY_FW_WR` cycles after the start edge.
- R7: Class 4 (resume) and the unused class codes 5 to 7 send only the opcode, then wait `DLY_RESUME` cycles. `done_o` rises 8·`BIT_CYC`+`DLY_RESUME` cycles after the start edge.
- R8: For classes 0 and 1, the transmitted address has bit 0 forced to zero.
- R9: `busy_o` is high from the cycle after an accepted start until the command ends. `done_o` is a single-cycle pulse in the first cycle with `busy_o` low again.
- R10: A `start_i` strobe while `busy_o` is high is ignored. It does not change the running command and does not start a second one.
- R11: With `ack_en_i` captured high, a wait ends on the first falling edge of the synchronized line instead of after its fixed count.
- R12: If no acknowledge edge arrives within `ACK_TMO_CYC` cycles, the wait ends and `err_o` goes high. `err_o` stays high until the next accepted start clears it.
- R13: A received bit is the line level sampled `SAMPLE_CYC` cycles into the bit, after a two-stage synchronizer. A low level gives 0, a high level gives 1, and bits are assembled most significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the unit of every bit time and wait |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| cls_i | input | 3 | Command class (0 hw read, 1 hw write, 2 fw read, 3 fw write, 4-7 resume) |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 16 | Address for hardware classes |
| wdata_i | input | 16 | Write data for write classes |
| ack_en_i | input | 1 | Replace fixed waits by acknowledge wait |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| rdata_o | output | 16 | Last received read word |
| err_o | output | 1 | Acknowledge timeout occurred in the last command |
| wire_i | input | 1 | Sensed level of the debug line |
| wire_low_o | output | 1 | Pull the debug line low (open-drain enable) |

## Verification
The bench keeps the default bit timing (16-cycle bits with 4, 13 and 2 cycle low pulses, sampling at cycle 10) and the default waits of 150, 48, 36 and 76 cycles. Every class therefore runs at its full length, and the end-of-command cycle is checked exactly. `ACK_TMO_CYC` is reduced to 60, so a missing acknowledge ends a hardware write well before a fixed wait would, and the timeout latency can be checked to the cycle. A target model in the bench decodes pulse widths into bits and pulls the line low for received zeros. This exposes the transmitted frame, the forced-even address and the received word at the ports.

// File: rtl/bgnd_pkg.sv
package bgnd_pkg;

  typedef enum logic [2:0] {
    CLS_HW_RD  = 3'd0,
    CLS_HW_WR  = 3'd1,
    CLS_FW_RD  = 3'd2,
    CLS_FW_WR  = 3'd3,
    CLS_RESUME = 3'd4
  } cmd_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDAT,
    ST_WAIT,
    ST_RDAT
  } seq_state_e;

  function automatic cmd_cls_e decode_cls(logic [2:0] raw);
    case (raw)
      3'd0:    return CLS_HW_RD;
      3'd1:    return CLS_HW_WR;
      3'd2:    return CLS_FW_RD;
      3'd3:    return CLS_FW_WR;
      default: return CLS_RESUME;
    endcase
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bgnd_bit_cell.sv
module bgnd_bit_cell #(
  parameter int BIT_CYC    = 16,
  parameter int LOW1_CYC   = 4,
  parameter int LOW0_CYC   = 13,
  parameter int RX_DRV_CYC = 2,
  parameter int SAMPLE_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rx_i,
  input  logic tx_bit_i,
  input  logic line_i,
  output logic drive_low_o,
  output logic bit_end_o,
  output logic rx_bit_o
);
  localparam int CW = $clog2(BIT_CYC);
  localparam logic [CW-1:0] LAST   = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] SAMPLE = CW'(SAMPLE_CYC);
  localparam logic [CW-1:0] L1     = CW'(LOW1_CYC);
  localparam logic [CW-1:0] L0     = CW'(LOW0_CYC);
  localparam logic [CW-1:0] LRX    = CW'(RX_DRV_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low_len;
  logic          rx_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_bit_q <= 1'b1;
    else if (run_i && rx_i && cnt_q == SAMPLE) rx_bit_q <= line_i;
  end

  always_comb begin
    if (rx_i)          low_len = LRX;
    else if (tx_bit_i) low_len = L1;
    else               low_len = L0;
  end

  assign drive_low_o = run_i && (cnt_q < low_len);
  assign bit_end_o   = run_i && (cnt_q == LAST);
  assign rx_bit_o    = rx_bit_q;
endmodule

// File: rtl/bgnd_wait_timer.sv
module bgnd_wait_timer #(
  parameter int WCW         = 9,
  parameter int ACK_TMO_CYC = 300
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [WCW-1:0] len_i,
  input  logic           ack_en_i,
  input  logic           ack_edge_i,
  output logic           fin_o,
  output logic           tmo_o
);
  localparam logic [WCW-1:0] TMO_LAST = WCW'(ACK_TMO_CYC - 1);

  logic [WCW-1:0] cnt_q;
  logic           tmo_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tmo_hit = (cnt_q == TMO_LAST);
  assign fin_o   = en_i && (ack_en_i ? (ack_edge_i || tmo_hit) : (cnt_q == len_i - 1'b1));
  assign tmo_o   = en_i && ack_en_i && !ack_edge_i && tmo_hit;
endmodule

// File: rtl/bgnd_cmd_seq.sv
module bgnd_cmd_seq
  import bgnd_pkg::*;
#(
  parameter int BIT_CYC     = 16,
  parameter int LOW1_CYC    = 4,
  parameter int LOW0_CYC    = 13,
  parameter int RX_DRV_CYC  = 2,
  parameter int SAMPLE_CYC  = 10,
  parameter int DLY_HW      = 150,
  parameter int DLY_FW_RD   = 48,
  parameter int DLY_FW_WR   = 36,
  parameter int DLY_RESUME  = 76,
  parameter int ACK_TMO_CYC = 300
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [2:0]  cls_i,
  input  logic [7:0]  opcode_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  input  logic        ack_en_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        err_o,
  input  logic        wire_i,
  output logic        wire_low_o
);
  localparam int MAX_WAIT = max2(max2(max2(DLY_HW, DLY_FW_RD), max2(DLY_FW_WR, DLY_RESUME)),
                                 ACK_TMO_CYC);
  localparam int WCW = $clog2(MAX_WAIT + 1);

  seq_state_e  state_q;
  cmd_cls_e    cls_q;
  logic        ack_en_q;
  logic [15:0] addr_q, wdata_q, shreg_q, rdata_q;
  logic [3:0]  idx_q;
  logic        err_q, done_q;
  logic [1:0]  sync_q;
  logic        line_prev_q;

  logic        line, ack_edge;
  logic        shifting, rx_mode, is_read;
  logic        bit_end, rx_bit, last_bit;
  logic        wait_fin, wait_tmo;
  logic [WCW-1:0] wait_len;

  // two-stage line synchronizer and falling-edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= 2'b11;
      line_prev_q <= 1'b1;
    end else begin
      sync_q      <= {sync_q[0], wire_i};
      line_prev_q <= sync_q[1];
    end
  end
  assign line     = sync_q[1];
  assign ack_edge = line_prev_q && !line;

  assign shifting = (state_q == ST_OPC) || (state_q == ST_ADDR) ||
                    (state_q == ST_WDAT) || (state_q == ST_RDAT);
  assign rx_mode  = (state_q == ST_RDAT);
  assign is_read  = (cls_q == CLS_HW_RD) || (cls_q == CLS_FW_RD);

  bgnd_bit_cell #(
    .BIT_CYC   (BIT_CYC),
    .LOW1_CYC  (LOW1_CYC),
    .LOW0_CYC  (LOW0_CYC),
    .RX_DRV_CYC(RX_DRV_CYC),
    .SAMPLE_CYC(SAMPLE_CYC)
  ) u_bit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (shifting),
    .rx_i       (rx_mode),
    .tx_bit_i   (shreg_q[15]),
    .line_i     (line),
    .drive_low_o(wire_low_o),
    .bit_end_o  (bit_end),
    .rx_bit_o   (rx_bit)
  );

  always_comb begin
    case (cls_q)
      CLS_HW_RD, CLS_HW_WR: wait_len = WCW'(DLY_HW);
      CLS_FW_RD:            wait_len = WCW'(DLY_FW_RD);
      CLS_FW_WR:            wait_len = WCW'(DLY_FW_WR);
      default:              wait_len = WCW'(DLY_RESUME);
    endcase
  end

  bgnd_wait_timer #(
    .WCW        (WCW),
    .ACK_TMO_CYC(ACK_TMO_CYC)
  ) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ST_WAIT),
    .len_i     (wait_len),
    .ack_en_i  (ack_en_q),
    .ack_edge_i(ack_edge),
    .fin_o     (wait_fin),
    .tmo_o     (wait_tmo)
  );

  assign last_bit = bit_end && ((state_q == ST_OPC) ? (idx_q == 4'd7) : (idx_q == 4'd15));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cls_q    <= CLS_RESUME;
      ack_en_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      shreg_q  <= '0;
      rdata_q  <= '0;
      idx_q    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cls_q    <= decode_cls(cls_i);
            ack_en_q <= ack_en_i;
            addr_q   <= {addr_i[15:1], 1'b0};
            wdata_q  <= wdata_i;
            shreg_q  <= {opcode_i, 8'h00};
            idx_q    <= '0;
            err_q    <= 1'b0;
            state_q  <= ST_OPC;
          end
        end
        ST_WAIT: begin
          if (wait_fin) begin
            if (wait_tmo) err_q <= 1'b1;
            if (is_read) begin
              state_q <= ST_RDAT;
              idx_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: begin
          if (bit_end) begin
            shreg_q <= rx_mode ? {shreg_q[14:0], rx_bit} : {shreg_q[14:0], 1'b0};
            idx_q   <= idx_q + 1'b1;
          end
          if (last_bit) begin
            idx_q <= '0;
            case (state_q)
              ST_OPC: begin
                if (cls_q == CLS_HW_RD || cls_q == CLS_HW_WR) begin
                  state_q <= ST_ADDR;
                  shreg_q <= addr_q;
                end else if (cls_q == CLS_FW_WR) begin
                  state_q <= ST_WDAT;
                  shreg_q <= wdata_q;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              ST_ADDR: begin
                if (cls_q == CLS_HW_WR) begin
                  state_q <= ST_WDAT;
                  shreg_q <= wdata_q;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              ST_WDAT: state_q <= ST_WAIT;
              default: begin
                rdata_q <= {shreg_q[14:0], rx_bit};
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/bgnd_cmd_seq_chk.sv
module bgnd_cmd_seq_chk #(
  parameter int LOW0_CYC = 13
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic wire_low_o
);
  logic [7:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  low_run_q <= '0;
    else if (!wire_low_o)         low_run_q <= '0;
    else if (low_run_q != 8'hff)  low_run_q <= low_run_q + 1'b1;
  end

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wire_low_o);

  // R1
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wire_low_o |-> (low_run_q < 8'(LOW0_CYC)));

  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R12
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

bind bgnd_cmd_seq bgnd_cmd_seq_chk #(.LOW0_CYC(LOW0_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .wire_low_o(wire_low_o)
);

// File: tb/bgnd_cmd_seq_tb.sv
module bgnd_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int B   = 16;
  localparam int TMO = 60;

  typedef struct {
    int          lat_min;
    int          lat_max;
    logic [15:0] rd;
    bit          chk_rd;
    bit          err;
    logic [39:0] tx;
    int          ntx;
    int          start_cyc;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ack_en = 1'b0;
  logic [2:0]  cls = '0;
  logic [7:0]  opc = '0;
  logic [15:0] addr = '0, wd = '0;
  logic busy, done, err, dut_low;
  logic [15:0] rdata;
  logic ack_low = 1'b0;
  logic wire_lvl;

  int cyc = 0, n_chk = 0, n_fail = 0, done_seen = 0, n_exp = 0, last_start = 0;
  bit finished = 0;
  item_t exp_q[$];

  // bench-side target model state
  logic [15:0] rx_val = '0;
  int cur_ntx = 0;
  logic clr = 1'b0;
  logic prev_low = 1'b0;
  int pidx = 0, wcnt = 0, tgt_cnt = 0, bad_w = 0;
  logic [39:0] got_tx = '0;

  assign wire_lvl = ~(dut_low | (tgt_cnt != 0) | ack_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  bgnd_cmd_seq #(.ACK_TMO_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cls_i(cls), .opcode_i(opc),
    .addr_i(addr), .wdata_i(wd), .ack_en_i(ack_en), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .err_o(err), .wire_i(wire_lvl), .wire_low_o(dut_low)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // target: decode pulse widths, pull line low for received zeros
  always @(posedge clk) begin
    prev_low <= dut_low;
    if (tgt_cnt != 0) tgt_cnt <= tgt_cnt - 1;
    if (clr) begin
      pidx <= 0; got_tx <= '0; bad_w <= 0; wcnt <= 0;
    end else begin
      if (dut_low && !prev_low) begin
        if (pidx >= cur_ntx && pidx - cur_ntx < 16)
          if (rx_val[15 - (pidx - cur_ntx)] == 1'b0) tgt_cnt <= 12;
        pidx <= pidx + 1;
      end
      if (dut_low) wcnt <= wcnt + 1;
      else if (prev_low) begin
        if (pidx - 1 < cur_ntx) begin
          got_tx <= {got_tx[38:0], (wcnt < 8)};
          if (wcnt != 4 && wcnt != 13) bad_w <= bad_w + 1;
        end
        wcnt <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected item at each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (exp_q.size() == 0) chk(0, "R9 R10 unexpected done", 1, 0);
      else begin
        item_t it;
        int lat;
        logic [39:0] m;
        it  = exp_q.pop_front();
        lat = cyc - it.start_cyc;
        m   = (40'd1 << it.ntx) - 40'd1;
        chk(lat >= it.lat_min && lat <= it.lat_max, {it.tag, " R2 latency"}, lat, it.lat_min);
        chk((got_tx & m) == (it.tx & m), {it.tag, " R1 frame"}, got_tx & m, it.tx & m);
        chk(bad_w == 0, {it.tag, " R1 pulse width"}, bad_w, 0);
        chk(err == it.err, {it.tag, " R12 err"}, err, it.err);
        chk(!busy, {it.tag, " R9 busy low at done"}, busy, 0);
        if (it.chk_rd) chk(rdata == it.rd, {it.tag, " R13 rdata"}, rdata, it.rd);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input logic [7:0] op, input logic [15:0] a,
                       input logic [15:0] w, input bit ack, input logic [15:0] rdv,
                       input int lmin, input int lmax, input bit experr, input string tag);
    item_t it;
    logic [15:0] ae;
    ae = {a[15:1], 1'b0};
    case (c)
      3'd0: begin it.tx = {16'h0, op, ae};  it.ntx = 24; it.lat_min = 40*B + 150; end
      3'd1: begin it.tx = {op, ae, w};      it.ntx = 40; it.lat_min = 40*B + 150; end
      3'd2: begin it.tx = {32'h0, op};      it.ntx = 8;  it.lat_min = 24*B + 48;  end
      3'd3: begin it.tx = {16'h0, op, w};   it.ntx = 24; it.lat_min = 24*B + 36;  end
      default: begin it.tx = {32'h0, op};   it.ntx = 8;  it.lat_min = 8*B + 76;   end
    endcase
    it.lat_max = it.lat_min;
    if (lmin >= 0) begin it.lat_min = lmin; it.lat_max = lmax; end
    it.rd = rdv; it.chk_rd = (c == 3'd0 || c == 3'd2); it.err = experr; it.tag = tag;
    rx_val = rdv; cur_ntx = it.ntx;
    @(negedge clk);
    cls = c; opc = op; addr = a; wd = w; ack_en = ack; start = 1'b1; clr = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    it.start_cyc = cyc; last_start = cyc;
    exp_q.push_back(it);
    n_exp++;
  endtask

  task automatic wait_done();
    while (done_seen < n_exp) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R9 reset busy", busy, 0);
    chk(done == 0, "R9 reset done", done, 0);
    chk(dut_low == 0, "R1 reset line released", dut_low, 0);
    chk(err == 0, "R12 reset err", err, 0);
    chk(rdata == 0, "R13 reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R8 R13: hardware read, odd address
    issue(3'd0, 8'hE0, 16'h1235, 16'h0, 0, 16'hA5C3, -1, -1, 0, "R3 R8 hw read");
    wait_done();
    // R4 R8: hardware write
    issue(3'd1, 8'hC0, 16'h4001, 16'hBEEF, 0, 16'h0, -1, -1, 0, "R4 R8 hw write");
    wait_done();
    // R5: firmware read
    issue(3'd2, 8'hE4, 16'h0, 16'h0, 0, 16'h6C91, -1, -1, 0, "R5 fw read");
    wait_done();
    // R6: firmware write
    issue(3'd3, 8'hC2, 16'h0, 16'h1234, 0, 16'h0, -1, -1, 0, "R6 fw write");
    wait_done();
    // R7: resume, and an unused class code
    issue(3'd4, 8'h08, 16'h0, 16'h0, 0, 16'h0, -1, -1, 0, "R7 resume");
    wait_done();
    issue(3'd7, 8'h10, 16'hFFFF, 16'hFFFF, 0, 16'h0, -1, -1, 0, "R7 unused class");
    wait_done();

    // R10: start while busy is ignored
    issue(3'd3, 8'hC8, 16'h0, 16'h00FF, 0, 16'h0, -1, -1, 0, "R10 busy ignore");
    repeat (50) @(negedge clk);
    chk(busy == 1, "R10 busy mid-command", busy, 1);
    cls = 3'd1; opc = 8'h55; wd = 16'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk(busy == 0, "R10 no second command", busy, 0);

    // R11: acknowledge ends the wait early
    issue(3'd3, 8'hC4, 16'h0, 16'hA0A0, 1, 16'h0, 24*B + 21, 24*B + 25, 0, "R11 ack wait");
    while (cyc < last_start + 24*B + 20) @(negedge clk);
    ack_low = 1'b1;
    repeat (4) @(negedge clk);
    ack_low = 1'b0;
    wait_done();

    // R12: no acknowledge, timeout sets err
    issue(3'd1, 8'h40, 16'h0010, 16'h5555, 1, 16'h0, 40*B + TMO, 40*B + TMO, 1, "R12 ack timeout");
    wait_done();
    repeat (5) @(negedge clk);
    chk(err == 1, "R12 err held", err, 1);
    // R12 R13: next command clears err; edge bits of read word
    issue(3'd2, 8'hE8, 16'h0, 16'h0, 0, 16'h8001, -1, -1, 0, "R12 R13 err cleared");
    wait_done();

    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", done_seen, n_exp);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule